// File: doc/BRIEF.md
# CPU Clock Level Change Sequencer

This block moves a CPU clock domain from its present performance level to a newly requested one. Sixteen levels exist, indexed 0 to 15. Level 0 is the fastest at 1700 MHz. Each higher index is 100 MHz slower, so level 15 runs at 200 MHz. A request names a target level. The sequencer looks up the PLL setting and the divider words for that level in constant tables. It then drives three command interfaces in the required order: the divider bank, the PLL configuration port and the core clock source mux. After each command it waits for the matching status before it continues.

The direction of a change sets the order of the steps. When speeding up, the dividers are written before the PLL moves. When slowing down, the PLL moves first and the dividers follow. When the old and new levels share the PLL multiplier and pre-divider, only the post-divider is rewritten. This short path skips the source bypass and the lock wait. Each status wait has a cycle limit. If the limit runs out, the change is abandoned and an error flag is raised.

Top module: `cpu_clk_stepper`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `div_wr`, `lock_wr`, `pll_wr` and `mux_alt` are 0, and `cur_level` is 9 (800 MHz).
- R2: `pll_cfg` carries the target level's PLL word. M is in bits 25:16, P in bits 13:8 and S in bits 2:0, and all other bits are 0. The M/P/S values per level are: 0:425/6/0, 1:200/3/0, 2:250/4/0, 3:175/3/0, 4:325/6/0, 5:200/4/0, 6:275/6/0, 7:125/3/0, 8:150/4/0, 9:100/3/0, 10:175/3/1, 11:200/4/1, 12:125/3/1, 13:100/3/1, 14:200/4/2, 15:100/3/2.
- R3: A divider update first writes word 0 (`div_sel`=0) and waits until every bit of `div_busy0` is 0. It then writes word 1 (`div_sel`=1) and waits until `div_busy1` is 0. Word 1 is always 32'h00000020. Word 0 depends on the level: 0:05377730, 1:04177730, 2:04177720, 3:04167720, 4:03167720, 5:03157720, 6:03157730, 7 to 9:02147710, 10 and 11:01137710, 12 and 13:01127710, 14 and 15:01117710 (hex).
- R4: A move to a lower index (speed-up) completes the divider update before any PLL write.
- R5: A move to a higher index (slow-down) completes the PLL update before the first divider write.
- R6: A full PLL update happens when M or P differs between the old and new levels. It runs in this order: raise `mux_alt`; wait for `mux_status` = 2; pulse `lock_wr` with `lock_count` = P×250; pulse `pll_wr` with `pll_s_only`=0; wait for `pll_locked`; drop `mux_alt`; wait for `mux_status` = 1.
- R7: When M and P match between the old and new levels, the PLL update is a single `pll_wr` pulse with `pll_s_only`=1. In that case `mux_alt` never rises and no `lock_wr` is issued.
- R8: A request for the level already in `cur_level` is ignored: `busy` stays 0 and no command strobe occurs.
- R9: A request is taken only while idle. `busy` is 1 from the cycle after acceptance through the single-cycle `done` pulse, and `cur_level` takes the target value in the `done` cycle. A request made while busy is dropped.
- R10: If a status wait lasts `TIMEOUT` cycles, the block returns to idle with `err`=1, gives no `done` pulse and leaves `cur_level` unchanged. `err` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Level change request strobe |
| req_level | input | 4 | Requested level index |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle end-of-change pulse |
| err | output | 1 | Last change timed out |
| cur_level | output | 4 | Level currently in force |
| div_wr | output | 1 | Divider word write strobe |
| div_sel | output | 1 | Divider word select (0 or 1) |
| div_data | output | 32 | Divider word value |
| div_busy0 | input | 8 | Busy bits of divider word 0 |
| div_busy1 | input | 2 | Busy bits of divider word 1 |
| mux_alt | output | 1 | Core source select: 1 = alternate PLL, 0 = main PLL |
| mux_status | input | 3 | Mux state: 1 = main, 2 = alternate |
| lock_wr | output | 1 | Lock count write strobe |
| lock_count | output | 16 | Lock time in reference cycles |
| pll_wr | output | 1 | PLL configuration write strobe |
| pll_s_only | output | 1 | Only the S field is to be applied |
| pll_cfg | output | 32 | PLL word (M, P, S) |
| pll_locked | input | 1 | PLL lock flag |

## Verification
A request is sampled at a rising edge, and `busy` reads high from the falling edge that follows. All command strobes come straight from the state register. Each strobe therefore lasts exactly one cycle and sits in a cycle of its own. The bench samples every output on falling edges and logs each strobe and each `mux_alt` transition once per cycle, so the order of steps and the data carried with each step are compared after the change has ended. The status models take a few cycles to answer. For that reason the bench waits for `done` (or for `busy` to fall in the timeout case) in a bounded loop instead of at a fixed cycle. It then checks that `done` was high for exactly one cycle and that `cur_level` changed in that same cycle.

// File: rtl/cpu_clk_stepper.sv
module cpu_clk_stepper #(
  parameter int RESET_LEVEL = 9,
  parameter int LOCK_MULT   = 250,
  parameter int LOCK_W      = 16,
  parameter int TIMEOUT     = 2048,
  parameter int DIV0_BUSY_W = 8,
  parameter int DIV1_BUSY_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [3:0]             req_level,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [3:0]             cur_level,
  output logic                   div_wr,
  output logic                   div_sel,
  output logic [31:0]            div_data,
  input  logic [DIV0_BUSY_W-1:0] div_busy0,
  input  logic [DIV1_BUSY_W-1:0] div_busy1,
  output logic                   mux_alt,
  input  logic [2:0]             mux_status,
  output logic                   lock_wr,
  output logic [LOCK_W-1:0]      lock_count,
  output logic                   pll_wr,
  output logic                   pll_s_only,
  output logic [31:0]            pll_cfg,
  input  logic                   pll_locked
);

  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam logic [2:0] MUX_ON_MAIN = 3'd1;
  localparam logic [2:0] MUX_ON_ALT  = 3'd2;
  localparam logic [31:0] DIV1_WORD  = 32'h0000_0020;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIV0_WR, ST_DIV0_WAIT, ST_DIV1_WR, ST_DIV1_WAIT,
    ST_S_WR, ST_MUX_ALT, ST_LOCK_WR, ST_PLL_WR, ST_LOCK_WAIT,
    ST_MUX_MAIN, ST_DONE
  } state_t;

  function automatic logic [31:0] pll_word(input logic [3:0] lvl);
    logic [9:0] m;
    logic [5:0] p;
    logic [2:0] s;
    case (lvl)
      4'd0:  begin m = 10'd425; p = 6'd6; s = 3'd0; end
      4'd1:  begin m = 10'd200; p = 6'd3; s = 3'd0; end
      4'd2:  begin m = 10'd250; p = 6'd4; s = 3'd0; end
      4'd3:  begin m = 10'd175; p = 6'd3; s = 3'd0; end
      4'd4:  begin m = 10'd325; p = 6'd6; s = 3'd0; end
      4'd5:  begin m = 10'd200; p = 6'd4; s = 3'd0; end
      4'd6:  begin m = 10'd275; p = 6'd6; s = 3'd0; end
      4'd7:  begin m = 10'd125; p = 6'd3; s = 3'd0; end
      4'd8:  begin m = 10'd150; p = 6'd4; s = 3'd0; end
      4'd9:  begin m = 10'd100; p = 6'd3; s = 3'd0; end
      4'd10: begin m = 10'd175; p = 6'd3; s = 3'd1; end
      4'd11: begin m = 10'd200; p = 6'd4; s = 3'd1; end
      4'd12: begin m = 10'd125; p = 6'd3; s = 3'd1; end
      4'd13: begin m = 10'd100; p = 6'd3; s = 3'd1; end
      4'd14: begin m = 10'd200; p = 6'd4; s = 3'd2; end
      default: begin m = 10'd100; p = 6'd3; s = 3'd2; end
    endcase
    return {6'b0, m, 2'b0, p, 5'b0, s};
  endfunction

  // fields 0, 2, 3 and 7 are fixed; the rest vary with the level
  function automatic logic [31:0] div0_word(input logic [3:0] lvl);
    logic [2:0] f1, f4, f5, f6;
    case (lvl)
      4'd0:  begin f1 = 3'd3; f4 = 3'd7; f5 = 3'd3; f6 = 3'd5; end
      4'd1:  begin f1 = 3'd3; f4 = 3'd7; f5 = 3'd1; f6 = 3'd4; end
      4'd2:  begin f1 = 3'd2; f4 = 3'd7; f5 = 3'd1; f6 = 3'd4; end
      4'd3:  begin f1 = 3'd2; f4 = 3'd6; f5 = 3'd1; f6 = 3'd4; end
      4'd4:  begin f1 = 3'd2; f4 = 3'd6; f5 = 3'd1; f6 = 3'd3; end
      4'd5:  begin f1 = 3'd2; f4 = 3'd5; f5 = 3'd1; f6 = 3'd3; end
      4'd6:  begin f1 = 3'd3; f4 = 3'd5; f5 = 3'd1; f6 = 3'd3; end
      4'd7, 4'd8, 4'd9:
             begin f1 = 3'd1; f4 = 3'd4; f5 = 3'd1; f6 = 3'd2; end
      4'd10, 4'd11:
             begin f1 = 3'd1; f4 = 3'd3; f5 = 3'd1; f6 = 3'd1; end
      4'd12, 4'd13:
             begin f1 = 3'd1; f4 = 3'd2; f5 = 3'd1; f6 = 3'd1; end
      default:
             begin f1 = 3'd1; f4 = 3'd1; f5 = 3'd1; f6 = 3'd1; end
    endcase
    return {4'h0, 1'b0, f6, 1'b0, f5, 1'b0, f4, 4'h7, 4'h7, 1'b0, f1, 4'h0};
  endfunction

  state_t           state, nxt;
  logic [3:0]       tgt, cur_r;
  logic             up_r, sonly_r, err_r;
  logic [TMO_W-1:0] tmo;
  logic             tmo_hit, fault, accept, up_req, match_req;
  logic [31:0]      cur_word, req_word, tgt_word;

  assign cur_word  = pll_word(cur_r);
  assign req_word  = pll_word(req_level);
  assign tgt_word  = pll_word(tgt);
  assign accept    = (state == ST_IDLE) && req_valid && (req_level != cur_r);
  assign up_req    = req_level < cur_r;
  assign match_req = cur_word[25:8] == req_word[25:8];
  assign tmo_hit   = tmo == TMO_W'(TIMEOUT - 1);

  always_comb begin
    nxt   = state;
    fault = 1'b0;
    case (state)
      ST_IDLE:
        if (accept) nxt = up_req ? ST_DIV0_WR : (match_req ? ST_S_WR : ST_MUX_ALT);
      ST_DIV0_WR: nxt = ST_DIV0_WAIT;
      ST_DIV0_WAIT:
        if (div_busy0 == '0) nxt = ST_DIV1_WR;
        else if (tmo_hit) fault = 1'b1;
      ST_DIV1_WR: nxt = ST_DIV1_WAIT;
      ST_DIV1_WAIT:
        if (div_busy1 == '0) nxt = up_r ? (sonly_r ? ST_S_WR : ST_MUX_ALT) : ST_DONE;
        else if (tmo_hit) fault = 1'b1;
      ST_S_WR: nxt = up_r ? ST_DONE : ST_DIV0_WR;
      ST_MUX_ALT:
        if (mux_status == MUX_ON_ALT) nxt = ST_LOCK_WR;
        else if (tmo_hit) fault = 1'b1;
      ST_LOCK_WR: nxt = ST_PLL_WR;
      ST_PLL_WR:  nxt = ST_LOCK_WAIT;
      ST_LOCK_WAIT:
        if (pll_locked) nxt = ST_MUX_MAIN;
        else if (tmo_hit) fault = 1'b1;
      ST_MUX_MAIN:
        if (mux_status == MUX_ON_MAIN) nxt = up_r ? ST_DONE : ST_DIV0_WR;
        else if (tmo_hit) fault = 1'b1;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (fault) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tgt     <= 4'(RESET_LEVEL);
      cur_r   <= 4'(RESET_LEVEL);
      up_r    <= 1'b0;
      sonly_r <= 1'b0;
      err_r   <= 1'b0;
      tmo     <= '0;
    end else begin
      state <= nxt;
      tmo   <= (state == ST_IDLE || nxt != state) ? '0 : tmo + 1'b1;
      if (accept) begin
        tgt     <= req_level;
        up_r    <= up_req;
        sonly_r <= match_req;
        err_r   <= 1'b0;
      end
      if (fault) err_r <= 1'b1;
      if (nxt == ST_DONE && state != ST_DONE) cur_r <= tgt;
    end
  end

  assign busy       = state != ST_IDLE;
  assign done       = state == ST_DONE;
  assign err        = err_r;
  assign cur_level  = cur_r;
  assign div_wr     = (state == ST_DIV0_WR) || (state == ST_DIV1_WR);
  assign div_sel    = state == ST_DIV1_WR;
  assign div_data   = div_sel ? DIV1_WORD : div0_word(tgt);
  assign mux_alt    = (state == ST_MUX_ALT) || (state == ST_LOCK_WR) ||
                      (state == ST_PLL_WR) || (state == ST_LOCK_WAIT);
  assign lock_wr    = state == ST_LOCK_WR;
  assign lock_count = LOCK_W'(tgt_word[13:8]) * LOCK_W'(LOCK_MULT);
  assign pll_wr     = (state == ST_PLL_WR) || (state == ST_S_WR);
  assign pll_s_only = state == ST_S_WR;
  assign pll_cfg    = tgt_word;

endmodule

module cpu_clk_stepper_chk #(
  parameter int DIV0_BUSY_W = 8,
  parameter int DIV1_BUSY_W = 2,
  parameter int LOCK_W      = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [3:0]             req_level,
  input logic                   busy,
  input logic                   done,
  input logic                   err,
  input logic [3:0]             cur_level,
  input logic                   div_wr,
  input logic                   div_sel,
  input logic [31:0]            div_data,
  input logic [DIV0_BUSY_W-1:0] div_busy0,
  input logic [DIV1_BUSY_W-1:0] div_busy1,
  input logic                   mux_alt,
  input logic [2:0]             mux_status,
  input logic                   lock_wr,
  input logic [LOCK_W-1:0]      lock_count,
  input logic                   pll_wr,
  input logic                   pll_s_only,
  input logic [31:0]            pll_cfg,
  input logic                   pll_locked
);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_level_moves_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> done);

  p_start_needs_new_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_valid) && $past(req_level) != $past(cur_level)));

  p_sonly_no_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_wr && pll_s_only) |-> !mux_alt);

  p_full_write_on_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_wr && !pll_s_only) |-> (mux_alt && mux_status == 3'd2));

  p_lock_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> (pll_wr && !pll_s_only));

  // R4 and R5: dividers are never touched while the core runs from the alternate source
  p_div_not_in_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> !mux_alt);

  p_timeout_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !done);

endmodule

bind cpu_clk_stepper cpu_clk_stepper_chk #(
  .DIV0_BUSY_W(DIV0_BUSY_W), .DIV1_BUSY_W(DIV1_BUSY_W), .LOCK_W(LOCK_W)
) u_chk (.*);

// File: tb/cpu_clk_stepper_bench.sv
module cpu_clk_stepper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_level = 4'd0;
  logic        busy, done, err, div_wr, div_sel, mux_alt, lock_wr, pll_wr, pll_s_only;
  logic [3:0]  cur_level;
  logic [31:0] div_data, pll_cfg;
  logic [15:0] lock_count;
  logic [7:0]  div_busy0;
  logic [1:0]  div_busy1;
  logic [2:0]  mux_status;
  logic        pll_locked;

  always #2 clk = ~clk;

  cpu_clk_stepper u_cpu_clk_stepper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .busy(busy), .done(done), .err(err), .cur_level(cur_level),
    .div_wr(div_wr), .div_sel(div_sel), .div_data(div_data),
    .div_busy0(div_busy0), .div_busy1(div_busy1),
    .mux_alt(mux_alt), .mux_status(mux_status),
    .lock_wr(lock_wr), .lock_count(lock_count),
    .pll_wr(pll_wr), .pll_s_only(pll_s_only), .pll_cfg(pll_cfg), .pll_locked(pll_locked)
  );

  // status models
  logic [2:0] c0, c1, pc, mc;
  logic       stall = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_busy0 <= '0; div_busy1 <= '0; c0 <= '0; c1 <= '0;
      mux_status <= 3'd1; mc <= '0; pll_locked <= 1'b1; pc <= '0;
    end else begin
      if (div_wr && !div_sel) begin div_busy0 <= '1; c0 <= 3'd3; end
      else if (c0 != 0) begin c0 <= c0 - 1'b1; if (c0 == 1) div_busy0 <= '0; end
      if (div_wr && div_sel) begin div_busy1 <= '1; c1 <= 3'd2; end
      else if (c1 != 0) begin c1 <= c1 - 1'b1; if (c1 == 1) div_busy1 <= '0; end
      if (pll_wr && !pll_s_only) begin pll_locked <= 1'b0; pc <= 3'd6; end
      else if (pc != 0) begin pc <= pc - 1'b1; if (pc == 1) pll_locked <= 1'b1; end
      if (!stall && mux_status != (mux_alt ? 3'd2 : 3'd1)) begin
        if (mc == 3'd2) begin mux_status <= mux_alt ? 3'd2 : 3'd1; mc <= '0; end
        else mc <= mc + 1'b1;
      end else mc <= '0;
    end
  end

  // event log: 1 div word0, 2 div word1, 3 mux to alt, 4 lock count, 5 full PLL, 6 S only, 7 mux to main
  logic [31:0] evlog = '0, last_d0 = '0, last_d1 = '0, last_cfg = '0;
  logic [15:0] last_lock = '0;
  logic        mux_prev = 1'b0;
  int          ndone = 0, nstrobe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (div_wr) begin
        evlog = {evlog[27:0], div_sel ? 4'h2 : 4'h1};
        if (div_sel) last_d1 = div_data; else last_d0 = div_data;
      end
      if (mux_alt && !mux_prev) evlog = {evlog[27:0], 4'h3};
      if (lock_wr) begin evlog = {evlog[27:0], 4'h4}; last_lock = lock_count; end
      if (pll_wr) begin evlog = {evlog[27:0], pll_s_only ? 4'h6 : 4'h5}; last_cfg = pll_cfg; end
      if (!mux_alt && mux_prev) evlog = {evlog[27:0], 4'h7};
      if (div_wr || lock_wr || pll_wr) nstrobe = nstrobe + 1;
      if (done) ndone = ndone + 1;
      mux_prev = mux_alt;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    evlog = '0; ndone = 0; nstrobe = 0;
  endtask

  task automatic request(input logic [3:0] lvl);
    @(negedge clk); req_valid = 1'b1; req_level = lvl;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic change(input logic [3:0] lvl, input logic [31:0] seq, input string req);
    clear_log();
    request(lvl);
    check({req, " R9 busy after accept"}, busy, 1'b1);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    check({req, " R9 done seen"}, done, 1'b1);
    check({req, " R9 level at done"}, cur_level, lvl);
    @(negedge clk);
    check({req, " R9 done one cycle"}, done, 1'b0);
    check({req, " R9 idle after done"}, busy, 1'b0);
    check({req, " step order"}, evlog, seq);
    check({req, " R9 single done"}, ndone, 1);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 1'b0);
    check("R1 done", done, 1'b0);
    check("R1 err", err, 1'b0);
    check("R1 strobes", {div_wr, lock_wr, pll_wr, mux_alt}, 4'b0);
    check("R1 level", cur_level, 4'd9);
  endtask

  task automatic t_same_level();
    clear_log();
    request(4'd9);
    check("R8 not busy", busy, 1'b0);
    repeat (10) @(negedge clk);
    check("R8 no strobes", nstrobe, 0);
    check("R8 level kept", cur_level, 4'd9);
  endtask

  task automatic t_speed_full();
    change(4'd2, 32'h0012_3457, "R4 R6 9->2");
    check("R3 word0 lvl2", last_d0, 32'h0417_7720);
    check("R3 word1", last_d1, 32'h0000_0020);
    check("R6 lock count P=4", last_lock, 16'd1000);
    check("R2 cfg lvl2", last_cfg, 32'h00FA_0400);
  endtask

  task automatic t_slow_full();
    change(4'd5, 32'h0034_5712, "R5 R6 2->5");
    check("R3 word0 lvl5", last_d0, 32'h0315_7720);
    check("R2 cfg lvl5", last_cfg, 32'h00C8_0400);
  endtask

  task automatic t_slow_sonly();
    change(4'd11, 32'h0000_0612, "R5 R7 5->11");
    check("R7 cfg lvl11", last_cfg, 32'h00C8_0401);
    check("R3 word0 lvl11", last_d0, 32'h0113_7710);
  endtask

  task automatic t_speed_sonly();
    change(4'd5, 32'h0000_0126, "R4 R7 11->5");
    check("R7 cfg lvl5", last_cfg, 32'h00C8_0400);
  endtask

  task automatic t_busy_request();
    clear_log();
    request(4'd0);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_level = 4'd15;
    @(negedge clk); req_valid = 1'b0;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    check("R9 first target kept", cur_level, 4'd0);
    repeat (15) @(negedge clk);
    check("R9 busy request dropped", busy, 1'b0);
    check("R9 level after drop", cur_level, 4'd0);
    check("R4 order 5->0", evlog, 32'h0012_3457);
    check("R6 lock count P=6", last_lock, 16'd1500);
  endtask

  task automatic t_timeout();
    clear_log();
    stall = 1'b1;
    request(4'd7);
    for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
    check("R10 back to idle", busy, 1'b0);
    check("R10 err set", err, 1'b1);
    check("R10 no done", ndone, 0);
    check("R10 level kept", cur_level, 4'd0);
    stall = 1'b0;
    repeat (10) @(negedge clk);
    change(4'd15, 32'h0034_5712, "R10 R5 recovery 0->15");
    check("R10 err cleared", err, 1'b0);
    check("R6 lock count lvl15", last_lock, 16'd750);
    check("R2 cfg lvl15", last_cfg, 32'h0064_0302);
    check("R3 word0 lvl15", last_d0, 32'h0111_7710);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_same_level();
    t_speed_full();
    t_slow_full();
    t_slow_sonly();
    t_speed_sonly();
    t_busy_request();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule